// File: doc/BRIEF.md
# Ordered Set and SKP Generator

This block builds the physical-layer ordered sets that a link training state machine asks for, one symbol per clock. It emits training sets of the first and second kind, plus periodic clock-compensation (SKP) sets. The symbol it builds is copied unchanged onto every lane. The link-number and lane-number fields of a training set always carry the PAD symbol. Any per-lane numbering is left to the lane datapaths that sit downstream.

SKP sets are scheduled by a free-running interval counter. A due SKP set never breaks into a packet: it waits for the packet-active flag to drop, and it also waits for a training set already on the wire to complete. Once due, it is sent before any new training set.

A separate handshake runs receiver detection over PIPE-style signals. It raises a detect request toward the PHY, waits for the PHY's status pulse, and then records whether a receiver answered.

Top module: `os_skp_gen`

## Requirements
- R1: While reset is asserted, osSel, every lane symbol, every lane K flag, txDetectRx, detectDone and rxPresent are all 0.
- R2: A SKP set lasts four symbols, all with K set: 0xBC (COM) first, then 0x1C three times. osSel is high for exactly those four cycles.
- R3: With no blocking traffic, consecutive SKP sets start exactly SKP_INTERVAL cycles apart. The first one starts SKP_INTERVAL+1 cycles after reset release. The interval counter keeps its phase when a set is deferred.
- R4: No ordered set starts on a clock edge where pktActive is high. A SKP set deferred by a packet starts on the first edge where pktActive is low.
- R5: A set of the first training kind is 16 symbols long. Symbol 0 is 0xBC (K), symbols 1 and 2 are 0xF7 PAD (K), symbol 3 is ftsCount, symbol 4 is rateField and symbol 5 is ctlField. Symbols 6 to 15 are the identifier 0x4A. Symbols 3 to 15 have K clear.
- R6: A set of the second training kind has the same layout as R5, with identifier 0x45. When both training requests are high, the second kind is sent.
- R7: While a training request stays high, sets follow each other with no idle cycle between them. Dropping the request in the middle of a set does not shorten that set.
- R8: A SKP set that is due when a set ends is sent before a new training set, even while a training request is held. A training set already in progress runs to its 16th symbol before the SKP set starts.
- R9: A cycle with detectReq high while idle raises txDetectRx on the next cycle. txDetectRx stays high until a cycle with phyStatus high. On the cycle after that, txDetectRx is low, detectDone pulses for exactly one cycle, and rxPresent becomes 1 if rxStatus was 3'b011 and 0 otherwise.
- R10: rxPresent holds its value between detections. A phyStatus pulse outside a detection changes neither rxPresent nor detectDone.
- R11: In any cycle with no ordered set, osSel is 0 and every lane symbol and K flag is 0.
- R12: Every lane carries the same symbol and K flag in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sendTs1 | input | 1 | Request for training sets of the first kind |
| sendTs2 | input | 1 | Request for training sets of the second kind (wins over sendTs1) |
| ftsCount | input | 8 | Fast-training-sequence count placed in symbol 3 |
| rateField | input | 8 | Data rate identifier placed in symbol 4 |
| ctlField | input | 8 | Training control bits placed in symbol 5 |
| pktActive | input | 1 | High while the link layer is sending a packet |
| detectReq | input | 1 | Starts a receiver detection |
| phyStatus | input | 1 | PHY completion pulse |
| rxStatus | input | 3 | PHY result code; 3'b011 means a receiver is present |
| laneData | output | LANES*8 | Per-lane symbol, lane n in bits [8n+7:8n] |
| laneIsK | output | LANES | Per-lane control-symbol flag |
| osSel | output | 1 | High when the lanes take the ordered-set stream instead of packet data |
| txDetectRx | output | 1 | Detect request toward the PHY |
| detectDone | output | 1 | One-cycle pulse when a detection finishes |
| rxPresent | output | 1 | Last detection result |

## Verification
The in-module assertions check several rules on every cycle: no set starts over an active packet, every set opens with COM, a training set advances one symbol at a time until it ends, a due SKP set wins at a set boundary, and the detect request and done pulse follow the handshake. The bench scenarios are the only place that shows the things a single-cycle property cannot. These are the exact SKP spacing and its phase after a deferral, the full symbol contents of both training kinds, the hand-over between back-to-back sets, and that an idle phyStatus pulse leaves the stored result alone.

// File: rtl/osgen_pkg.sv
package osgen_pkg;
  localparam int SYM_W = 8;
  localparam int TS_LEN = 16;
  localparam int SKP_LEN = 4;
  localparam int IDX_W = $clog2(TS_LEN);

  localparam logic [SYM_W-1:0] SYM_COM = 8'hBC;
  localparam logic [SYM_W-1:0] SYM_SKP = 8'h1C;
  localparam logic [SYM_W-1:0] SYM_PAD = 8'hF7;
  localparam logic [SYM_W-1:0] ID_TS1  = 8'h4A;
  localparam logic [SYM_W-1:0] ID_TS2  = 8'h45;

  typedef enum logic [1:0] {OS_NONE, OS_SKP, OS_TS1, OS_TS2} osKind_e;

  typedef struct packed {
    logic             active;
    osKind_e          kind;
    logic [IDX_W-1:0] idx;
  } osStrobe_t;
endpackage

// File: rtl/osgen_ctrl.sv
module osgen_ctrl
  import osgen_pkg::*;
#(
  parameter int SKP_INTERVAL = 1180
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sendTs1,
  input  logic       sendTs2,
  input  logic       pktActive,
  input  logic       detectReq,
  input  logic       phyStatus,
  input  logic [2:0] rxStatus,
  output osStrobe_t  strb,
  output logic       txDetectRx,
  output logic       detectDone,
  output logic       rxPresent
);
  localparam int CNT_W = (SKP_INTERVAL > 2) ? $clog2(SKP_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SKP_INTERVAL - 1);
  localparam logic [IDX_W-1:0] SKP_END = IDX_W'(SKP_LEN - 1);
  localparam logic [IDX_W-1:0] TS_END = IDX_W'(TS_LEN - 1);

  logic [CNT_W-1:0] intCnt;
  logic             skpPending;
  osKind_e          kind, nextKind;
  logic [IDX_W-1:0] idx;
  logic             lastSym, atBoundary, expire, startSkp, isTs;
  logic             detBusy;

  assign isTs = (kind == OS_TS1) || (kind == OS_TS2);
  assign lastSym = ((kind == OS_SKP) && (idx == SKP_END)) || (isTs && (idx == TS_END));
  assign atBoundary = (kind == OS_NONE) || lastSym;
  assign expire = (intCnt == CNT_LAST);
  assign startSkp = atBoundary && !pktActive && skpPending;

  always_comb begin
    nextKind = kind;
    if (atBoundary) begin
      if (pktActive)       nextKind = OS_NONE;
      else if (skpPending) nextKind = OS_SKP;
      else if (sendTs2)    nextKind = OS_TS2;
      else if (sendTs1)    nextKind = OS_TS1;
      else                 nextKind = OS_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
      skpPending <= 1'b0;
      kind <= OS_NONE;
      idx <= '0;
    end else begin
      intCnt <= expire ? '0 : intCnt + CNT_W'(1);
      skpPending <= expire | (skpPending & ~startSkp);
      kind <= nextKind;
      idx <= atBoundary ? '0 : idx + IDX_W'(1);
    end
  end

  assign strb.active = (kind != OS_NONE);
  assign strb.kind = kind;
  assign strb.idx = idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detBusy <= 1'b0;
      detectDone <= 1'b0;
      rxPresent <= 1'b0;
    end else begin
      detectDone <= 1'b0;
      if (!detBusy && detectReq) begin
        detBusy <= 1'b1;
      end else if (detBusy && phyStatus) begin
        detBusy <= 1'b0;
        detectDone <= 1'b1;
        rxPresent <= (rxStatus == 3'b011);
      end
    end
  end

  assign txDetectRx = detBusy;

  // R4: an idle stream stays idle across an edge with a packet in flight
  p_defer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.active && pktActive) |=> !strb.active);

  // R8: a due SKP set wins at the end of a set
  p_skp_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lastSym && skpPending && !pktActive) |=> (kind == OS_SKP && idx == '0));

  // R7: a training set is never cut short
  p_ts_whole_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isTs && !lastSym) |=> (kind == $past(kind) && idx == $past(idx) + IDX_W'(1)));

  // R9: the detect request holds until the PHY answers
  p_det_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txDetectRx && !phyStatus) |=> txDetectRx);

  // R9: the completion flag is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    detectDone |=> !detectDone);
endmodule

// File: rtl/osgen_dp.sv
module osgen_dp
  import osgen_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  osStrobe_t              strb,
  input  logic [SYM_W-1:0]       ftsCount,
  input  logic [SYM_W-1:0]       rateField,
  input  logic [SYM_W-1:0]       ctlField,
  output logic [LANES*SYM_W-1:0] laneData,
  output logic [LANES-1:0]       laneIsK,
  output logic                   osSel
);
  logic [SYM_W-1:0] sym;
  logic             symK;
  logic [SYM_W-1:0] tsId;

  assign tsId = (strb.kind == OS_TS2) ? ID_TS2 : ID_TS1;

  always_comb begin
    sym = '0;
    symK = 1'b0;
    unique case (strb.kind)
      OS_SKP: begin
        symK = 1'b1;
        sym = (strb.idx == '0) ? SYM_COM : SYM_SKP;
      end
      OS_TS1, OS_TS2: begin
        case (strb.idx)
          IDX_W'(0): begin sym = SYM_COM; symK = 1'b1; end
          IDX_W'(1), IDX_W'(2): begin sym = SYM_PAD; symK = 1'b1; end
          IDX_W'(3): sym = ftsCount;
          IDX_W'(4): sym = rateField;
          IDX_W'(5): sym = ctlField;
          default:   sym = tsId;
        endcase
      end
      default: begin
        sym = '0;
        symK = 1'b0;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneData[g*SYM_W +: SYM_W] = sym;
    assign laneIsK[g] = symK;
  end

  assign osSel = strb.active;

  // R2 / R5: every ordered set opens with the comma control symbol
  p_com_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.active) |-> (sym == SYM_COM && symK));
endmodule

// File: rtl/os_skp_gen.sv
module os_skp_gen
  import osgen_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SKP_INTERVAL = 1180
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sendTs1,
  input  logic                 sendTs2,
  input  logic [7:0]           ftsCount,
  input  logic [7:0]           rateField,
  input  logic [7:0]           ctlField,
  input  logic                 pktActive,
  input  logic                 detectReq,
  input  logic                 phyStatus,
  input  logic [2:0]           rxStatus,
  output logic [LANES*8-1:0]   laneData,
  output logic [LANES-1:0]     laneIsK,
  output logic                 osSel,
  output logic                 txDetectRx,
  output logic                 detectDone,
  output logic                 rxPresent
);
  osStrobe_t strb;

  osgen_ctrl #(.SKP_INTERVAL(SKP_INTERVAL)) i_ctrl (
    .clk(clk), .rstN(rstN), .sendTs1(sendTs1), .sendTs2(sendTs2),
    .pktActive(pktActive), .detectReq(detectReq), .phyStatus(phyStatus),
    .rxStatus(rxStatus), .strb(strb), .txDetectRx(txDetectRx),
    .detectDone(detectDone), .rxPresent(rxPresent)
  );

  osgen_dp #(.LANES(LANES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ftsCount(ftsCount),
    .rateField(rateField), .ctlField(ctlField), .laneData(laneData),
    .laneIsK(laneIsK), .osSel(osSel)
  );
endmodule

// File: tb/test_os_skp_gen.sv
module test_os_skp_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int IVL = 40;

  logic clk = 1'b0;
  logic rstN, sendTs1, sendTs2, pktActive, detectReq, phyStatus;
  logic [7:0] ftsCount, rateField, ctlField;
  logic [2:0] rxStatus;
  logic [LANES*8-1:0] laneData;
  logic [LANES-1:0] laneIsK;
  logic osSel, txDetectRx, detectDone, rxPresent;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_skp_gen #(.LANES(LANES), .SKP_INTERVAL(IVL)) i_os_skp_gen (
    .clk(clk), .rstN(rstN), .sendTs1(sendTs1), .sendTs2(sendTs2),
    .ftsCount(ftsCount), .rateField(rateField), .ctlField(ctlField),
    .pktActive(pktActive), .detectReq(detectReq), .phyStatus(phyStatus),
    .rxStatus(rxStatus), .laneData(laneData), .laneIsK(laneIsK),
    .osSel(osSel), .txDetectRx(txDetectRx), .detectDone(detectDone),
    .rxPresent(rxPresent)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  // R12: every lane compared against the same expectation
  task automatic expectSym(input string tag, input logic [7:0] d, input logic k, input logic sel);
    for (int l = 0; l < LANES; l++) begin
      chk({tag, " data"}, int'(laneData[l*8 +: 8]), int'(d));
      chk({tag, " K"}, int'(laneIsK[l]), int'(k));
    end
    chk({tag, " osSel"}, int'(osSel), int'(sel));
  endtask

  task automatic idleTo(input string tag, input int n);
    while (cyc < n) begin
      step();
      expectSym(tag, 8'h00, 1'b0, 1'b0);
    end
  endtask

  task automatic expectSkp(input string tag);
    for (int i = 0; i < 4; i++) begin
      step();
      expectSym(tag, (i == 0) ? 8'hBC : 8'h1C, 1'b1, 1'b1);
    end
  endtask

  task automatic expectTs(input string tag, input logic [7:0] id, input bit dropReq);
    logic [7:0] e;
    logic ek;
    for (int i = 0; i < 16; i++) begin
      step();
      ek = (i < 3);
      case (i)
        0: e = 8'hBC;
        1, 2: e = 8'hF7;
        3: e = ftsCount;
        4: e = rateField;
        5: e = ctlField;
        default: e = id;
      endcase
      expectSym(tag, e, ek, 1'b1);
      if (i == 0 && dropReq) begin
        sendTs1 = 1'b0;
        sendTs2 = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sendTs1 = 1'b0; sendTs2 = 1'b0; pktActive = 1'b0;
    detectReq = 1'b0; phyStatus = 1'b0; rxStatus = 3'b000;
    ftsCount = 8'h1F; rateField = 8'h02; ctlField = 8'h00;
    repeat (3) @(negedge clk);
    expectSym("R1 reset", 8'h00, 1'b0, 1'b0);
    chk("R1 txDetectRx", int'(txDetectRx), 0);
    chk("R1 detectDone", int'(detectDone), 0);
    chk("R1 rxPresent", int'(rxPresent), 0);
    rstN = 1'b1;
    cyc = 0;

    // R3 first SKP at IVL+1, R11 idle before it, R2 format
    idleTo("R11 idle", IVL);
    expectSkp("R2 skp");
    idleTo("R11 idle", 2*IVL);
    expectSkp("R3 interval");

    // R4 deferral behind a packet
    idleTo("R11 idle", 2*IVL + 10);
    pktActive = 1'b1;
    idleTo("R4 held", 3*IVL + 20);
    pktActive = 1'b0;
    expectSkp("R4 after packet");
    idleTo("R11 idle", 4*IVL);
    expectSkp("R3 phase kept");

    // R5, R7 back-to-back, R8 SKP before next set
    idleTo("R11 idle", 4*IVL + 10);
    sendTs1 = 1'b1;
    expectTs("R5 ts1", 8'h4A, 1'b0);
    expectTs("R7 back-to-back", 8'h4A, 1'b0);
    expectSkp("R8 skp wins");
    expectTs("R7 not cut", 8'h4A, 1'b1);
    idleTo("R11 idle", 6*IVL - 15);

    // R6 second kind wins, R8 running set finishes first
    ftsCount = 8'h80; rateField = 8'h06; ctlField = 8'h01;
    sendTs1 = 1'b1; sendTs2 = 1'b1;
    expectTs("R6 ts2", 8'h45, 1'b1);
    expectSkp("R8 after ts2");
    step();
    expectSym("R11 idle", 8'h00, 1'b0, 1'b0);

    // R9 detect handshake with receiver present
    detectReq = 1'b1;
    step();
    chk("R9 txDetectRx up", int'(txDetectRx), 1);
    chk("R9 no done yet", int'(detectDone), 0);
    detectReq = 1'b0;
    step();
    step();
    chk("R9 txDetectRx holds", int'(txDetectRx), 1);
    phyStatus = 1'b1; rxStatus = 3'b011;
    step();
    chk("R9 txDetectRx down", int'(txDetectRx), 0);
    chk("R9 done pulse", int'(detectDone), 1);
    chk("R9 present", int'(rxPresent), 1);
    phyStatus = 1'b0; rxStatus = 3'b000;
    step();
    chk("R9 done one cycle", int'(detectDone), 0);
    chk("R10 present held", int'(rxPresent), 1);

    // R10 stray phyStatus while idle
    phyStatus = 1'b1;
    step();
    chk("R10 stray no done", int'(detectDone), 0);
    chk("R10 stray keeps result", int'(rxPresent), 1);
    chk("R10 no request", int'(txDetectRx), 0);
    phyStatus = 1'b0;

    // R9 detect with no receiver
    detectReq = 1'b1;
    step();
    chk("R9 second request", int'(txDetectRx), 1);
    detectReq = 1'b0;
    phyStatus = 1'b1; rxStatus = 3'b000;
    step();
    chk("R9 second done", int'(detectDone), 1);
    chk("R9 absent", int'(rxPresent), 0);
    phyStatus = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule